// File: doc/BRIEF.md
# Two-Stage DMA Trigger Router

This block links pairs of DMA channels so that finishing work on one channel starts another without software. Each channel has a channel-role field and a trigger-level field. A channel can have no role. It can also be the upstream (source) side or the downstream (destination) side of one of two independent pairing groups. Every channel reports four kinds of completion through its own done pulses: fragment, block, transaction and link-list. When the source of a group reports the completion level named in its own trigger-level field, the router pulses the start line of that group's destination channel.

The router also checks the configuration on every cycle. If two channels claim the same role in one group, that group raises the configuration-error flag and that group alone is silenced. An out-of-range value in any role or trigger-level field silences every group. The router moves no data: it only decodes roles, pairs channels and issues start pulses.

Top module: `dlr_trigger_router`

## Requirements
- R1: While reset is held and on the first cycle after it, `dst_start` is all zero and `cfg_err` is 0.
- R2: Role codes per channel are 0 = no role, 1 = source of group 0, 2 = source of group 1, 3 = destination of group 0, 4 = destination of group 1. A qualifying event on a group's source pulses the start bit of that group's destination channel only.
- R3: Trigger-level codes are 1 = fragment done, 2 = block done, 3 = transaction done and 4 = link-list done. Done pulses of the other kinds on the source channel cause no start.
- R4: A source whose trigger-level field is 0 never causes a start.
- R5: The trigger level is taken from the source channel of the group. The destination channel's own trigger-level field has no effect.
- R6: A start is a single-cycle pulse that appears on the cycle after the qualifying done pulse. Done pulses on back-to-back cycles give starts on back-to-back cycles. With no done pulse there is no start.
- R7: Both groups work at the same time and independently. Events for both groups in one cycle start both destinations in the next cycle.
- R8: If two or more channels hold the same source code, or the same destination code, of one group, `cfg_err` is 1 on the following cycle and that group issues no start. The other group keeps working.
- R9: A role or trigger-level value above 4 on any channel sets `cfg_err` on the following cycle and suppresses every start.
- R10: A channel with role 0, or with a source role, never receives a start. Done pulses on a destination channel or on a channel with role 0 cause no start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_mode | input | NCH*8 | Role code per channel, channel c at bits [8c+7:8c] |
| trig_mode | input | NCH*8 | Trigger-level code per channel, same packing |
| frag_done | input | NCH | Fragment-complete pulse per channel |
| blk_done | input | NCH | Block-complete pulse per channel |
| xfer_done | input | NCH | Transaction-complete pulse per channel |
| list_done | input | NCH | Link-list-complete pulse per channel |
| dst_start | output | NCH | Registered start pulse per channel |
| cfg_err | output | 1 | Registered configuration-error flag |

## Verification
Directed cases put each completion kind against each trigger level on a fixed pair. This shows that only the matching level fires and that the destination's own field is ignored. Pulses on the destination and on unassigned channels show that events are taken only from the source. Firing both groups in one cycle, then doubling a role in one group, shows that the groups are independent and that a conflict silences only its own group. Out-of-range codes show the global shutdown. Random role layouts with random multi-channel done patterns then compare every cycle against a bench model, which covers overlapping events and frequent reconfiguration.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
    localparam int FIELD_W = 8;
    localparam int NUM_GRP = 2;

    typedef enum logic [FIELD_W-1:0] {
        ROLE_NONE = 8'd0,
        ROLE_SRC0 = 8'd1,
        ROLE_SRC1 = 8'd2,
        ROLE_DST0 = 8'd3,
        ROLE_DST1 = 8'd4
    } role_e;

    typedef enum logic [FIELD_W-1:0] {
        TRG_OFF  = 8'd0,
        TRG_FRAG = 8'd1,
        TRG_BLK  = 8'd2,
        TRG_XFER = 8'd3,
        TRG_LIST = 8'd4
    } trig_e;

    function automatic logic [FIELD_W-1:0] src_code(input int g);
        return FIELD_W'(int'(ROLE_SRC0) + g);
    endfunction

    function automatic logic [FIELD_W-1:0] dst_code(input int g);
        return FIELD_W'(int'(ROLE_DST0) + g);
    endfunction
endpackage

// File: rtl/dlr_chan_decode.sv
module dlr_chan_decode
    import dlr_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [NCH*FIELD_W-1:0]        chan_mode,
    input  logic [NCH*FIELD_W-1:0]        trig_mode,
    input  logic [NCH-1:0]                frag_done,
    input  logic [NCH-1:0]                blk_done,
    input  logic [NCH-1:0]                xfer_done,
    input  logic [NCH-1:0]                list_done,
    output logic [NUM_GRP-1:0][NCH-1:0]   src_mask,
    output logic [NUM_GRP-1:0][NCH-1:0]   dst_mask,
    output logic [NCH-1:0]                chan_evt,
    output logic                          bad_value
);
    logic [NCH-1:0] bad_ch;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [FIELD_W-1:0] cm;
        logic [FIELD_W-1:0] tm;
        logic               evt;

        assign cm = chan_mode[c*FIELD_W +: FIELD_W];
        assign tm = trig_mode[c*FIELD_W +: FIELD_W];

        // select the completion level this channel reports upward
        always_comb begin
            case (tm)
                TRG_FRAG: evt = frag_done[c];
                TRG_BLK:  evt = blk_done[c];
                TRG_XFER: evt = xfer_done[c];
                TRG_LIST: evt = list_done[c];
                default:  evt = 1'b0;
            endcase
        end

        assign chan_evt[c] = evt;
        assign bad_ch[c]   = (cm > ROLE_DST1) || (tm > TRG_LIST);

        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            assign src_mask[g][c] = (cm == src_code(g));
            assign dst_mask[g][c] = (cm == dst_code(g));
        end
    end

    assign bad_value = |bad_ch;
endmodule

// File: rtl/dlr_group_pair.sv
module dlr_group_pair #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] src_mask,
    input  logic [NCH-1:0] dst_mask,
    input  logic [NCH-1:0] chan_evt,
    input  logic           glob_bad,
    output logic [NCH-1:0] start,
    output logic           dup_err
);
    localparam int CNT_W = $clog2(NCH + 1);

    function automatic logic [CNT_W-1:0] ones(input logic [NCH-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < NCH; i++) n = n + CNT_W'(v[i]);
        return n;
    endfunction

    logic src_fire;

    always_comb begin
        dup_err  = (ones(src_mask) > CNT_W'(1)) || (ones(dst_mask) > CNT_W'(1));
        src_fire = |(src_mask & chan_evt);
        start    = (src_fire && !dup_err && !glob_bad) ? dst_mask : '0;
    end
endmodule

// File: rtl/dlr_trigger_router.sv
module dlr_trigger_router
    import dlr_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH*FIELD_W-1:0] chan_mode,
    input  logic [NCH*FIELD_W-1:0] trig_mode,
    input  logic [NCH-1:0]         frag_done,
    input  logic [NCH-1:0]         blk_done,
    input  logic [NCH-1:0]         xfer_done,
    input  logic [NCH-1:0]         list_done,
    output logic [NCH-1:0]         dst_start,
    output logic                   cfg_err
);
    typedef struct packed {
        logic [NCH-1:0] start;
        logic           err;
    } out_t;

    out_t out_d;
    out_t out_q;

    logic [NUM_GRP-1:0][NCH-1:0] src_mask;
    logic [NUM_GRP-1:0][NCH-1:0] dst_mask;
    logic [NCH-1:0]              chan_evt;
    logic                        bad_value;
    logic [NUM_GRP-1:0][NCH-1:0] grp_start;
    logic [NUM_GRP-1:0]          grp_dup;

    dlr_chan_decode #(.NCH(NCH)) u_decode (
        .chan_mode (chan_mode),
        .trig_mode (trig_mode),
        .frag_done (frag_done),
        .blk_done  (blk_done),
        .xfer_done (xfer_done),
        .list_done (list_done),
        .src_mask  (src_mask),
        .dst_mask  (dst_mask),
        .chan_evt  (chan_evt),
        .bad_value (bad_value)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
        dlr_group_pair #(.NCH(NCH)) u_pair (
            .src_mask (src_mask[g]),
            .dst_mask (dst_mask[g]),
            .chan_evt (chan_evt),
            .glob_bad (bad_value),
            .start    (grp_start[g]),
            .dup_err  (grp_dup[g])
        );
    end

    always_comb begin
        out_d     = '0;
        out_d.err = bad_value;
        for (int g = 0; g < NUM_GRP; g++) begin
            out_d.start = out_d.start | grp_start[g];
            out_d.err   = out_d.err | grp_dup[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dst_start = out_q.start;
    assign cfg_err   = out_q.err;
endmodule

// File: rtl/dlr_router_chk.sv
module dlr_router_chk #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH*8-1:0] chan_mode,
    input logic [NCH*8-1:0] trig_mode,
    input logic [NCH-1:0]   frag_done,
    input logic [NCH-1:0]   blk_done,
    input logic [NCH-1:0]   xfer_done,
    input logic [NCH-1:0]   list_done,
    input logic [NCH-1:0]   dst_start,
    input logic             cfg_err
);
    logic past_ok;
    logic any_bad;
    logic any_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        any_bad = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (chan_mode[c*8 +: 8] > 8'd4 || trig_mode[c*8 +: 8] > 8'd4) any_bad = 1'b1;
        end
        any_done = |(frag_done | blk_done | xfer_done | list_done);
    end

    // R6
    no_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_done |=> (dst_start == '0));

    // R9
    bad_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_bad |=> (cfg_err && dst_start == '0));

    // R7
    start_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dst_start) <= 2);

    for (genvar c = 0; c < NCH; c++) begin : g_role
        // R10
        dst_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && dst_start[c]) |->
            ($past(chan_mode[c*8 +: 8]) == 8'd3 || $past(chan_mode[c*8 +: 8]) == 8'd4));
    end
endmodule

bind dlr_trigger_router dlr_router_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_mode (chan_mode),
    .trig_mode (trig_mode),
    .frag_done (frag_done),
    .blk_done  (blk_done),
    .xfer_done (xfer_done),
    .list_done (list_done),
    .dst_start (dst_start),
    .cfg_err   (cfg_err)
);

// File: tb/dlr_trigger_router_test.sv
module dlr_trigger_router_test;
    localparam int NCH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH*8-1:0] chan_mode;
    logic [NCH*8-1:0] trig_mode;
    logic [NCH-1:0]   frag_done = '0;
    logic [NCH-1:0]   blk_done = '0;
    logic [NCH-1:0]   xfer_done = '0;
    logic [NCH-1:0]   list_done = '0;
    logic [NCH-1:0]   dst_start;
    logic             cfg_err;

    logic [7:0] cm_a [NCH];
    logic [7:0] tm_a [NCH];

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [NCH-1:0] exp_start;
    logic           exp_err;

    always #10ns clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            chan_mode[c*8 +: 8] = cm_a[c];
            trig_mode[c*8 +: 8] = tm_a[c];
        end
    end

    dlr_trigger_router #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode), .trig_mode(trig_mode),
        .frag_done(frag_done), .blk_done(blk_done), .xfer_done(xfer_done),
        .list_done(list_done), .dst_start(dst_start), .cfg_err(cfg_err)
    );

    // expected {err, start} for the inputs applied in one cycle
    function automatic logic [NCH:0] model();
        logic           bad = 1'b0;
        logic           err;
        logic [NCH-1:0] st = '0;
        for (int c = 0; c < NCH; c++)
            if (cm_a[c] > 8'd4 || tm_a[c] > 8'd4) bad = 1'b1;
        err = bad;
        for (int g = 0; g < 2; g++) begin
            int ns = 0, nd = 0, si = 0, di = 0;
            logic ev;
            for (int c = 0; c < NCH; c++) begin
                if (cm_a[c] == 8'(1 + g)) begin ns++; si = c; end
                if (cm_a[c] == 8'(3 + g)) begin nd++; di = c; end
            end
            if (ns > 1 || nd > 1) err = 1'b1;
            else if (!bad && ns == 1 && nd == 1) begin
                case (tm_a[si])
                    8'd1: ev = frag_done[si];
                    8'd2: ev = blk_done[si];
                    8'd3: ev = xfer_done[si];
                    8'd4: ev = list_done[si];
                    default: ev = 1'b0;
                endcase
                if (ev) st[di] = 1'b1;
            end
        end
        return {err, st};
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (dst_start !== exp_start || cfg_err !== exp_err) begin
            fails++;
            $display("FAIL %s: start=%b err=%b expected start=%b err=%b",
                     tag, dst_start, cfg_err, exp_start, exp_err);
        end
    endtask

    // apply current inputs for one cycle, then check the registered result
    task automatic cyc(input string tag);
        {exp_err, exp_start} = model();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        frag_done = '0; blk_done = '0; xfer_done = '0; list_done = '0;
    endtask

    task automatic clr_cfg();
        for (int c = 0; c < NCH; c++) begin cm_a[c] = 8'd0; tm_a[c] = 8'd0; end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        clr_cfg();
        repeat (3) @(negedge clk);
        exp_start = '0; exp_err = 1'b0;
        compare("R1 reset");
        rst_n = 1'b1;
        // R1: first cycle out of reset with nothing pending
        cyc("R1");

        // R2 group 0: source ch2 on fragment, destination ch5
        cm_a[2] = 8'd1; tm_a[2] = 8'd1; cm_a[5] = 8'd3;
        frag_done[2] = 1'b1; cyc("R2");
        if (dst_start !== 8'b0010_0000) begin fails++; $display("FAIL R2: start=%b expected 00100000", dst_start); end
        checks++;
        cyc("R6 pulse ends");
        frag_done[2] = 1'b1; cyc("R6 back1");
        frag_done[2] = 1'b1; cyc("R6 back2");
        // R3: wrong kinds ignored, each level selects its kind
        blk_done[2] = 1'b1; xfer_done[2] = 1'b1; list_done[2] = 1'b1; cyc("R3 other kinds");
        tm_a[2] = 8'd2; blk_done[2] = 1'b1; cyc("R3 block");
        tm_a[2] = 8'd3; xfer_done[2] = 1'b1; frag_done[2] = 1'b1; cyc("R3 transaction");
        tm_a[2] = 8'd4; list_done[2] = 1'b1; cyc("R3 list");
        tm_a[2] = 8'd4; blk_done[2] = 1'b1; cyc("R3 list vs block");
        // R4 / R5
        tm_a[2] = 8'd0; tm_a[5] = 8'd3;
        frag_done = '1; blk_done = '1; xfer_done = '1; list_done = '1; cyc("R4 off");
        tm_a[2] = 8'd1; tm_a[5] = 8'd2; blk_done[2] = 1'b1; cyc("R5 dst field ignored");
        // R10: events on destination / unassigned channels
        tm_a[6] = 8'd1; frag_done[5] = 1'b1; frag_done[6] = 1'b1; cyc("R10 dst and idle events");
        // R7: group 1 ch0 -> ch7, both fire together
        cm_a[0] = 8'd2; tm_a[0] = 8'd3; cm_a[7] = 8'd4;
        xfer_done[0] = 1'b1; frag_done[2] = 1'b1; cyc("R7 both groups");
        if (dst_start !== 8'b1010_0000) begin fails++; $display("FAIL R7: start=%b expected 10100000", dst_start); end
        checks++;
        // R8: duplicate group 0 source
        cm_a[3] = 8'd1; tm_a[3] = 8'd1;
        frag_done[2] = 1'b1; frag_done[3] = 1'b1; xfer_done[0] = 1'b1; cyc("R8 dup src");
        cm_a[3] = 8'd4; frag_done[2] = 1'b1; xfer_done[0] = 1'b1; cyc("R8 dup dst");
        cm_a[3] = 8'd0; cyc("R8 cleared");
        // R9: out-of-range values
        cm_a[6] = 8'd9; frag_done[2] = 1'b1; xfer_done[0] = 1'b1; cyc("R9 role");
        cm_a[6] = 8'd0; tm_a[4] = 8'd5; frag_done[2] = 1'b1; cyc("R9 trigger");
        tm_a[4] = 8'd0; frag_done[2] = 1'b1; cyc("R9 recovered");

        // random layouts and event patterns
        for (int it = 0; it < 4000; it++) begin
            if (($urandom % 16) == 0) begin
                clr_cfg();
                for (int r = 1; r <= 4; r++) cm_a[$urandom % NCH] = 8'(r);
                if (($urandom % 6) == 0) cm_a[$urandom % NCH] = 8'(1 + $urandom % 4);
                if (($urandom % 12) == 0) cm_a[$urandom % NCH] = 8'(5 + $urandom % 200);
                for (int c = 0; c < NCH; c++)
                    tm_a[c] = (($urandom % 40) == 0) ? 8'(5 + $urandom % 9) : 8'($urandom % 5);
            end
            for (int c = 0; c < NCH; c++) begin
                frag_done[c] = ($urandom % 3) == 0;
                blk_done[c]  = ($urandom % 3) == 0;
                xfer_done[c] = ($urandom % 4) == 0;
                list_done[c] = ($urandom % 5) == 0;
            end
            cyc("R2 R7 random");
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule